// File: doc/BRIEF.md
# Stop-Mode Power Controller

This controller manages the deepest power-save state of a small microcontroller. It runs from the always-on subclock. Software puts the core to sleep in two steps. It first sets a power-save select flag, then writes a stop request. From that point the CPU clock, the peripheral clock and the main oscillator are all switched off. The subclock enable stays on throughout.

While stopped, the controller watches for wake-up events without any help from the main clock. These events are a non-maskable request, unmasked external and peripheral interrupt levels, and a watchdog interrupt that counts only while the CPU runs on the subclock.

When a wake event arrives, the oscillator is restarted and a programmable stabilization count runs. The CPU and peripheral clocks return only after that count ends. At that point the controller reports, for one cycle, one of two outcomes:
- the waking request must be acknowledged, so the core branches to its handler;
- the core only resumes at the next instruction, and the request is left pending in the interrupt controller.

The reset pin, and a watchdog reset while on the subclock, take the reset path instead.

States: RUN (normal operation), STOP (clocks and oscillator off), SETTLE (oscillator stabilizing), RESUME (one-cycle result report). Transitions:
- RUN→STOP: a stop request is written while power-save is selected.
- STOP→SETTLE: a wake event occurs.
- SETTLE→RESUME: the count reaches zero.
- RESUME→RUN: always.
- Any→RUN: reset.

Top module: `stopctl_top`

## Requirements
- R1: After reset, `mode_o` is 0 (RUN), `cpu_clk_en`, `per_clk_en`, `osc_en` and `sub_clk_en` are 1, and `result` is 0.
- R2: Writes are decoded by `wr_sel` as follows:
  - `wr_sel`=0 loads the power-save flag from `wr_data[0]`.
  - `wr_sel`=1 with `wr_data[1]`=1 is a stop request.
  - `wr_sel`=2 loads the settle count from `wr_data[CNT_W-1:0]`.

  STOP (`mode_o`=1) is entered on the edge of a stop request only from RUN and only when the flag is 1. Otherwise the request is ignored.
- R3: In STOP, `cpu_clk_en`, `per_clk_en` and `osc_en` are 0 while `sub_clk_en` stays 1.
- R4: These events wake the controller from STOP:
  - `nmi`;
  - any `ext_irq` or `per_irq` bit whose mask bit is 0 (mask 1 blocks it);
  - `wdt_irq`, but only while `on_subclk` is 1.

  Wake inputs are level-sensitive.
- R5: After the wake edge, `mode_o` is 2 (SETTLE) for exactly S+1 cycles, where S is the settle count. During SETTLE, `osc_en` is 1 and `cpu_clk_en` and `per_clk_en` are 0. Then `mode_o` is 3 (RESUME) for one cycle with all clocks enabled, then 0.
- R6: A wake that includes `nmi`, or `wdt_irq` with `on_subclk`, reports `result`=3 (acknowledge non-maskable) in RESUME, whatever `int_en` is.
- R7: A wake by maskable requests only, with `int_en`=0, reports `result`=1 (resume only).
- R8: With `int_en`=1, let P be the lowest 3-bit priority value among active unmasked requests (lower value means more urgent).
  - If `in_isr`=1 and P is not less than `isr_prio`, the report is `result`=1.
  - Otherwise the report is `result`=2 (acknowledge maskable).

  The verdict uses the inputs sampled on the wake edge.
- R9: `wdt_rst` with `on_subclk`=1 returns the controller to RUN on the next edge and clears all registers, including the power-save flag. `wdt_rst` with `on_subclk`=0 is ignored. A low `rst_n` returns the controller to RUN immediately.
- R10: `result` is 0 in every state other than RESUME.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Subclock, always running |
| rst_n | input | 1 | Asynchronous reset pin, active low |
| wdt_rst | input | 1 | Watchdog reset request |
| on_subclk | input | 1 | CPU is running on the subclock |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 flag, 1 control, 2 settle count |
| wr_data | input | WR_W | Write data |
| nmi | input | 1 | Non-maskable request level |
| wdt_irq | input | 1 | Watchdog interrupt level |
| ext_irq | input | N_EXT | External interrupt levels |
| ext_mask | input | N_EXT | External masks, 1 blocks |
| ext_prio | input | N_EXT*PW | External priorities, PW bits each |
| per_irq | input | N_PER | Stop-capable peripheral interrupt levels |
| per_mask | input | N_PER | Peripheral masks, 1 blocks |
| per_prio | input | N_PER*PW | Peripheral priorities |
| int_en | input | 1 | Interrupts enabled (EI) |
| in_isr | input | 1 | A service routine is in progress |
| isr_prio | input | PW | Priority of the routine in service |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Main oscillator enable |
| sub_clk_en | output | 1 | Subclock enable |
| result | output | 2 | Wake result: 0 none, 1 resume, 2 ack maskable, 3 ack NMI |
| mode_o | output | 2 | State: 0 RUN, 1 STOP, 2 SETTLE, 3 RESUME |

## Verification
A full sweep applies every request priority against every in-service priority, under all four combinations of `int_en` and `in_isr`. This separates the strict-less comparison from an off-by-one and shows that DI forces resume-only. Each external and peripheral line is woken alone, which exposes a wrong lane or a wrong mask polarity. Two simultaneous requests show that the most urgent one is the one judged. Settle counts of 0, 1, 5 and 2 fix the exact length of SETTLE, and masked lines and the watchdog off the subclock show which sources must not wake.

// File: rtl/stopctl_pkg.sv
package stopctl_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'd0,
        PM_STOP   = 2'd1,
        PM_SETTLE = 2'd2,
        PM_RESUME = 2'd3
    } pm_state_t;

    typedef enum logic [1:0] {
        RC_NONE     = 2'd0,
        RC_RESUME   = 2'd1,
        RC_ACK_MASK = 2'd2,
        RC_ACK_NMI  = 2'd3
    } rc_t;

    localparam logic [1:0] SEL_MODE   = 2'd0;
    localparam logic [1:0] SEL_CTRL   = 2'd1;
    localparam logic [1:0] SEL_SETTLE = 2'd2;

    localparam int STOP_BIT  = 1;
    localparam int PSAVE_BIT = 0;

endpackage

// File: rtl/stopctl_regs.sv
module stopctl_regs
    import stopctl_pkg::*;
#(
    parameter int WR_W = 8,
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] SETTLE_INIT = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [WR_W-1:0]  wr_data,
    output logic             psave_q,
    output logic [CNT_W-1:0] settle_q,
    output logic             stop_req
);

    // stop request is a write strobe, not a stored bit
    assign stop_req = wr_en && (wr_sel == SEL_CTRL) && wr_data[STOP_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psave_q  <= 1'b0;
            settle_q <= SETTLE_INIT;
        end else if (sync_clr) begin
            psave_q  <= 1'b0;
            settle_q <= SETTLE_INIT;
        end else if (wr_en) begin
            if (wr_sel == SEL_MODE)
                psave_q <= wr_data[PSAVE_BIT];
            if (wr_sel == SEL_SETTLE)
                settle_q <= wr_data[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/stopctl_wake.sv
module stopctl_wake
    import stopctl_pkg::*;
#(
    parameter int N_EXT = 7,
    parameter int N_PER = 4,
    parameter int PW = 3
) (
    input  logic                nmi,
    input  logic                wdt_irq,
    input  logic                on_subclk,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic [N_EXT-1:0]    ext_mask,
    input  logic [N_EXT*PW-1:0] ext_prio,
    input  logic [N_PER-1:0]    per_irq,
    input  logic [N_PER-1:0]    per_mask,
    input  logic [N_PER*PW-1:0] per_prio,
    input  logic                int_en,
    input  logic                in_isr,
    input  logic [PW-1:0]       isr_prio,
    output logic                wake,
    output rc_t                 verdict
);

    localparam int N_ALL = N_EXT + N_PER;

    logic [N_ALL-1:0]    live;
    logic [N_ALL*PW-1:0] prio_flat;
    logic [PW-1:0]       prio_arr [N_ALL];
    logic [PW-1:0]       best;
    logic                any_mask;
    logic                nmi_hit;

    assign live      = {per_irq & ~per_mask, ext_irq & ~ext_mask};
    assign prio_flat = {per_prio, ext_prio};

    genvar gi;
    generate
        for (gi = 0; gi < N_ALL; gi++) begin : g_slice
            assign prio_arr[gi] = prio_flat[gi*PW +: PW];
        end
    endgenerate

    // most urgent (numerically lowest) active priority
    always_comb begin
        best     = '1;
        any_mask = 1'b0;
        for (int i = 0; i < N_ALL; i++) begin
            if (live[i]) begin
                any_mask = 1'b1;
                if (prio_arr[i] < best)
                    best = prio_arr[i];
            end
        end
    end

    assign nmi_hit = nmi || (wdt_irq && on_subclk);
    assign wake    = nmi_hit || any_mask;

    always_comb begin
        if (nmi_hit)
            verdict = RC_ACK_NMI;
        else if (!any_mask)
            verdict = RC_NONE;
        else if (!int_en)
            verdict = RC_RESUME;
        else if (in_isr && !(best < isr_prio))
            verdict = RC_RESUME;
        else
            verdict = RC_ACK_MASK;
    end

endmodule

// File: rtl/stopctl_settle.sv
module stopctl_settle #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             run,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (sync_clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/stopctl_top.sv
module stopctl_top
    import stopctl_pkg::*;
#(
    parameter int N_EXT = 7,
    parameter int N_PER = 4,
    parameter int PW = 3,
    parameter int WR_W = 8,
    parameter int CNT_W = 8,
    parameter logic [CNT_W-1:0] SETTLE_INIT = 8'd15
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wdt_rst,
    input  logic                on_subclk,
    input  logic                wr_en,
    input  logic [1:0]          wr_sel,
    input  logic [WR_W-1:0]     wr_data,
    input  logic                nmi,
    input  logic                wdt_irq,
    input  logic [N_EXT-1:0]    ext_irq,
    input  logic [N_EXT-1:0]    ext_mask,
    input  logic [N_EXT*PW-1:0] ext_prio,
    input  logic [N_PER-1:0]    per_irq,
    input  logic [N_PER-1:0]    per_mask,
    input  logic [N_PER*PW-1:0] per_prio,
    input  logic                int_en,
    input  logic                in_isr,
    input  logic [PW-1:0]       isr_prio,
    output logic                cpu_clk_en,
    output logic                per_clk_en,
    output logic                osc_en,
    output logic                sub_clk_en,
    output logic [1:0]          result,
    output logic [1:0]          mode_o
);

    pm_state_t        state_q, state_d;
    rc_t              res_q, verdict;
    logic             wdt_clr;
    logic             psave_q, stop_req;
    logic [CNT_W-1:0] settle_q;
    logic             wake, done;
    logic             arm;

    assign wdt_clr = wdt_rst && on_subclk;
    assign arm     = (state_q == PM_STOP) && wake;

    stopctl_regs #(.WR_W(WR_W), .CNT_W(CNT_W), .SETTLE_INIT(SETTLE_INIT)) u_regs (
        .clk(clk), .rst_n(rst_n), .sync_clr(wdt_clr),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .psave_q(psave_q), .settle_q(settle_q), .stop_req(stop_req)
    );

    stopctl_wake #(.N_EXT(N_EXT), .N_PER(N_PER), .PW(PW)) u_wake (
        .nmi(nmi), .wdt_irq(wdt_irq), .on_subclk(on_subclk),
        .ext_irq(ext_irq), .ext_mask(ext_mask), .ext_prio(ext_prio),
        .per_irq(per_irq), .per_mask(per_mask), .per_prio(per_prio),
        .int_en(int_en), .in_isr(in_isr), .isr_prio(isr_prio),
        .wake(wake), .verdict(verdict)
    );

    stopctl_settle #(.CNT_W(CNT_W)) u_settle (
        .clk(clk), .rst_n(rst_n), .sync_clr(wdt_clr),
        .load(arm), .load_val(settle_q),
        .run(state_q == PM_SETTLE), .done(done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PM_RUN:    if (stop_req && psave_q) state_d = PM_STOP;
            PM_STOP:   if (wake)                state_d = PM_SETTLE;
            PM_SETTLE: if (done)                state_d = PM_RESUME;
            PM_RESUME:                          state_d = PM_RUN;
            default:                            state_d = PM_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PM_RUN;
        else if (wdt_clr)
            state_q <= PM_RUN;
        else
            state_q <= state_d;
    end

    // verdict captured on the wake edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            res_q <= RC_NONE;
        else if (wdt_clr)
            res_q <= RC_NONE;
        else if (arm)
            res_q <= verdict;
    end

    // outputs
    always_comb begin
        sub_clk_en = 1'b1;
        mode_o     = state_q;
        result     = RC_NONE;
        cpu_clk_en = 1'b1;
        per_clk_en = 1'b1;
        osc_en     = 1'b1;
        unique case (state_q)
            PM_RUN: begin
            end
            PM_STOP: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
                osc_en     = 1'b0;
            end
            PM_SETTLE: begin
                cpu_clk_en = 1'b0;
                per_clk_en = 1'b0;
            end
            PM_RESUME: begin
                result = res_q;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/stopctl_chk.sv
module stopctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wdt_rst,
    input logic       on_subclk,
    input logic       nmi,
    input logic       cpu_clk_en,
    input logic       per_clk_en,
    input logic       osc_en,
    input logic       sub_clk_en,
    input logic [1:0] result,
    input logic [1:0] mode_o
);

    AST_STOP_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && $past(mode_o) != 2'd1) |-> $past(mode_o) == 2'd0) // R2
        else $error("stop entered from a state other than run");

    AST_STOP_CLOCKS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd1 |-> (!cpu_clk_en && !per_clk_en && !osc_en && sub_clk_en)) // R3
        else $error("clocks running in stop");

    AST_NMI_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd1 && nmi && !(wdt_rst && on_subclk)) |=> mode_o == 2'd2) // R4
        else $error("nmi did not wake");

    AST_SETTLE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 2'd2 && $past(mode_o) != 2'd2) |-> $past(mode_o) == 2'd1) // R5
        else $error("settle not preceded by stop");

    AST_SETTLE_OSC: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd2 |-> (osc_en && !cpu_clk_en && !per_clk_en)) // R5
        else $error("wrong enables in settle");

    AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o == 2'd3 |=> mode_o == 2'd0) // R5
        else $error("resume lasted more than one cycle");

    AST_WDT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst && on_subclk) |=> mode_o == 2'd0) // R9
        else $error("watchdog reset ignored");

    AST_RESULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3 |-> result == 2'd0) // R10
        else $error("result outside resume");

endmodule

bind stopctl_top stopctl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .on_subclk(on_subclk),
    .nmi(nmi), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en), .sub_clk_en(sub_clk_en), .result(result), .mode_o(mode_o)
);

// File: tb/stopctl_top_test.sv
`timescale 1ns/1ps
module stopctl_top_test;

    localparam int N_EXT = 7;
    localparam int N_PER = 4;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wdt_rst = 1'b0, on_subclk = 1'b0;
    logic wr_en = 1'b0;
    logic [1:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic nmi = 1'b0, wdt_irq = 1'b0;
    logic [N_EXT-1:0] ext_irq = '0, ext_mask = '0;
    logic [N_EXT*PW-1:0] ext_prio = '0;
    logic [N_PER-1:0] per_irq = '0, per_mask = '0;
    logic [N_PER*PW-1:0] per_prio = '0;
    logic int_en = 1'b1, in_isr = 1'b0;
    logic [PW-1:0] isr_prio = '0;
    logic cpu_clk_en, per_clk_en, osc_en, sub_clk_en;
    logic [1:0] result, mode_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    stopctl_top uut (
        .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .on_subclk(on_subclk),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .nmi(nmi), .wdt_irq(wdt_irq),
        .ext_irq(ext_irq), .ext_mask(ext_mask), .ext_prio(ext_prio),
        .per_irq(per_irq), .per_mask(per_mask), .per_prio(per_prio),
        .int_en(int_en), .in_isr(in_isr), .isr_prio(isr_prio),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .sub_clk_en(sub_clk_en), .result(result), .mode_o(mode_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic enter_stop();
        wr(2'd1, 8'h02);
        chk("R2 enter stop", mode_o, 1);
    endtask

    // caller has just raised wake inputs at a falling edge
    task automatic wake_check(input int exp_code, input int exp_len, input string tag);
        int n = 0;
        @(negedge clk);
        nmi = 0; wdt_irq = 0; ext_irq = '0; per_irq = '0;
        while (mode_o == 2'd2 && n < 400) begin
            if (n == 0) chk("R5 settle enables", {osc_en, cpu_clk_en, per_clk_en}, 3'b100);
            n++;
            @(negedge clk);
        end
        if (exp_len >= 0) chk("R5 settle length", n, exp_len);
        chk({tag, " resume mode"}, mode_o, 3);
        chk({tag, " result"}, result, exp_code);
        @(negedge clk);
        chk("R10 result after resume", result, 0);
        chk("R5 back to run", mode_o, 0);
    endtask

    initial begin
        #1_200_000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", mode_o, 0);
        chk("R1 enables", {cpu_clk_en, per_clk_en, osc_en, sub_clk_en}, 4'hF);
        chk("R1 result", result, 0);

        // R2 stop write without power-save flag is ignored
        wr(2'd1, 8'h02);
        chk("R2 no psave", mode_o, 0);
        wr(2'd0, 8'h01);
        wr(2'd1, 8'h01); // stop bit clear
        chk("R2 stop bit clear", mode_o, 0);
        wr(2'd2, 8'd2);

        // R3 enables in stop
        enter_stop();
        chk("R3 stop enables", {cpu_clk_en, per_clk_en, osc_en, sub_clk_en}, 4'h1);
        chk("R10 result in stop", result, 0);

        // R4 masked line and watchdog off subclock do not wake
        ext_mask[0] = 1'b1; ext_irq[0] = 1'b1; per_mask[2] = 1'b1; per_irq[2] = 1'b1;
        repeat (3) @(negedge clk);
        chk("R4 masked no wake", mode_o, 1);
        ext_irq = '0; per_irq = '0; ext_mask = '0; per_mask = '0;
        wdt_irq = 1'b1; on_subclk = 1'b0;
        repeat (3) @(negedge clk);
        chk("R4 wdt irq off subclk", mode_o, 1);
        // R6 watchdog on subclock acknowledged as non-maskable
        on_subclk = 1'b1;
        wake_check(3, 3, "R6 wdt");
        on_subclk = 1'b0;

        // R5 settle lengths
        foreach (ext_irq[k]) begin end
        for (int s = 0; s < 3; s++) begin
            int sv = (s == 0) ? 0 : (s == 1) ? 1 : 5;
            wr(2'd2, 8'(sv));
            enter_stop();
            nmi = 1'b1;
            wake_check(3, sv + 1, "R6 nmi");
        end
        wr(2'd2, 8'd2);

        // R6 nmi under DI
        int_en = 1'b0;
        enter_stop();
        nmi = 1'b1;
        wake_check(3, 3, "R6 nmi di");
        int_en = 1'b1;

        // R4 each line alone
        for (int i = 0; i < N_EXT; i++) begin
            enter_stop();
            ext_irq[i] = 1'b1;
            wake_check(2, 3, "R4 ext line");
        end
        for (int j = 0; j < N_PER; j++) begin
            enter_stop();
            per_irq[j] = 1'b1;
            wake_check(2, 3, "R4 per line");
        end

        // R7 R8 priority sweep on external line 3
        for (int e = 0; e < 2; e++) begin
            for (int q = 0; q < 2; q++) begin
                for (int ip = 0; ip < 8; ip++) begin
                    for (int rp = 0; rp < 8; rp++) begin
                        int ex;
                        if (e == 0) ex = 1;
                        else if (q == 1 && !(rp < ip)) ex = 1;
                        else ex = 2;
                        enter_stop();
                        int_en = e[0]; in_isr = q[0]; isr_prio = ip[2:0];
                        ext_prio[3*PW +: PW] = rp[2:0];
                        ext_irq[3] = 1'b1;
                        wake_check(ex, 3, (e == 0) ? "R7 di sweep" : "R8 prio sweep");
                    end
                end
            end
        end

        // R8 most urgent of two requests decides
        ext_prio = '0;
        int_en = 1'b1; in_isr = 1'b1; isr_prio = 3'd3;
        enter_stop();
        ext_prio[0 +: PW] = 3'd5; ext_prio[PW +: PW] = 3'd1;
        ext_irq[0] = 1'b1; ext_irq[1] = 1'b1;
        wake_check(2, 3, "R8 two req urgent");
        enter_stop();
        ext_prio[PW +: PW] = 3'd4;
        ext_irq[0] = 1'b1; ext_irq[1] = 1'b1;
        wake_check(1, 3, "R8 two req lesser");
        in_isr = 1'b0;

        // R9 watchdog reset
        enter_stop();
        on_subclk = 1'b0; wdt_rst = 1'b1;
        @(negedge clk);
        chk("R9 wdt rst off subclk", mode_o, 1);
        on_subclk = 1'b1;
        @(negedge clk);
        wdt_rst = 1'b0; on_subclk = 1'b0;
        chk("R9 wdt rst to run", mode_o, 0);
        wr(2'd1, 8'h02);
        chk("R9 psave cleared", mode_o, 0);

        // R9 async reset pin
        wr(2'd0, 8'h01);
        enter_stop();
        #1 rst_n = 1'b0;
        #1 chk("R9 pin reset", mode_o, 0);
        chk("R9 pin reset enables", {cpu_clk_en, osc_en}, 2'b11);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule